// File: doc/BRIEF.md
# Reference Frequency Monitor with Holdover Steering

This block watches a slow reference clock, nominally 8 kHz, from the local crystal-derived timebase. It measures every reference period in local clock cycles and accepts a period only when it falls inside a tolerance window around nominal. The window is set in parts per million. After a run of consecutive accepted periods it raises a safe flag. While the flag is high, each accepted period nudges a digital oscillator control word by a signed step proportional to the period error. The local oscillator, modelled here only by that word, therefore follows the reference.

When the reference stops, or a period lands outside the window, the flag drops and the control word freezes at its last value. The oscillator keeps running on the last good correction without a glitch. When edges return, the block qualifies them again and resumes steering from the held word, with no command from outside. A frequency-select input picks buffer mode with codes 1110 and 1111. In buffer mode, monitoring and steering are bypassed and the 8 kHz output enable is released.

Top module: `refmon_holdover`

## Requirements
- R1: After reset `safe_o` is 0 and `ctrl_word_o` is mid-scale, 2^(CW_W-1) (128 for CW_W=8). `out8k_oe_o` is 1 whenever the select code is not a buffer code.
- R2: A period P is the count of local cycles between two consecutive synchronised rising edges of `ref_clk_i`. P is in range when NOM_CYCLES-TOL <= P <= NOM_CYCLES+TOL, with TOL = floor(NOM_CYCLES*TOL_PPM/1e6). The first edge after reset or after a loss only starts timing and yields no period.
- R3: `safe_o` goes high on the period that completes LOCK_PERIODS consecutive in-range periods, which is rising edge LOCK_PERIODS+1 of a stable reference. It stays high while periods remain in range.
- R4: A period out of range clears `safe_o` and restarts the consecutive count from zero.
- R5: If more than 2*NOM_CYCLES local cycles pass with no rising edge, the reference is lost. `safe_o` clears and the next edge only starts timing. A gap of exactly 2*NOM_CYCLES is still measured, and it is an out-of-range period.
- R6: While `safe_o` is high, each in-range period sets the word to word - (P-NOM_CYCLES)*GAIN, saturated to 0 and 2^CW_W-1.
- R7: The word does not change while `safe_o` is low (holdover). This includes the period that raises `safe_o` and any out-of-range period.
- R8: With `fsel_i` = 1110 or 1111 (buffer mode), `safe_o` is 0, the word is frozen and `out8k_oe_o` is 0. After leaving buffer mode, qualification restarts from a zero count.
- R9: After a loss, steering resumes by itself once qualification completes, and it continues from the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local crystal-derived timebase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk |
| fsel_i | input | 4 | Frequency select code; 1110 and 1111 select buffer mode |
| safe_o | output | 1 | High while the reference is qualified and in range |
| ctrl_word_o | output | CW_W | Oscillator control word |
| out8k_oe_o | output | 1 | Output enable of the 8 kHz output, low in buffer mode |

## Verification
The bench sweeps the period across and past both window edges, one cycle at a time. A design whose bounds were off by one would either accept 389 or 411 or reject 390 or 410, and the safe flag and word would then diverge from the model. Runs of the extreme in-range periods drive the word into both rails, which exposes a wrap instead of saturation. Gaps of exactly twice nominal and one cycle longer separate a measured bad period from a loss. A design that confused the two would re-qualify one edge early or one edge late. Buffer-mode entry and exit, and the edge that raises the flag, check that the word stays frozen and that the count restarts from zero.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  localparam logic [2:0] FSEL_BUF_PREFIX = 3'b111;

  function automatic logic is_buffer_code(input logic [3:0] code);
    return code[3:1] == FSEL_BUF_PREFIX;
  endfunction

endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = async_i;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/refmon_period_meter.sv
module refmon_period_meter #(
  parameter int NOM_CYCLES = 24000,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o,
  output logic             lost_o
);

  localparam int TIMEOUT = 2 * NOM_CYCLES;
  localparam logic [CNT_W-1:0] TIMEOUT_C = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] ONE_C     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             vld_q, vld_d;
  logic             lost_q, lost_d;
  logic             armed_q, armed_d;
  logic             meas_en;

  always_comb begin
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    vld_d   = 1'b0;
    lost_d  = 1'b0;
    armed_d = armed_q;
    meas_en = 1'b0;
    if (rise_i) begin
      cnt_d   = ONE_C;
      meas_en = 1'b1;
      meas_d  = cnt_q;
      vld_d   = armed_q;
      armed_d = 1'b1;
    end else begin
      if (cnt_q != TIMEOUT_C) begin
        cnt_d = cnt_q + ONE_C;
      end
      if (armed_q && (cnt_q >= TIMEOUT_C)) begin
        lost_d  = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      lost_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      lost_q  <= lost_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= '0;
    end else if (meas_en) begin
      meas_q <= meas_d;
    end
  end

  assign meas_o     = meas_q;
  assign meas_vld_o = vld_q;
  assign lost_o     = lost_q;

endmodule

// File: rtl/refmon_qualifier.sv
module refmon_qualifier #(
  parameter int NOM_CYCLES   = 24000,
  parameter int TOL_CYCLES   = 6,
  parameter int LOCK_PERIODS = 4,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             meas_vld_i,
  input  logic             lost_i,
  input  logic             bypass_i,
  output logic             safe_o,
  output logic             upd_o
);

  localparam int SK_W = $clog2(LOCK_PERIODS + 1);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(NOM_CYCLES - TOL_CYCLES);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(NOM_CYCLES + TOL_CYCLES);
  localparam logic [SK_W-1:0]  LOCK_C      = SK_W'(LOCK_PERIODS);
  localparam logic [SK_W-1:0]  LOCK_LAST_C = SK_W'(LOCK_PERIODS - 1);
  localparam logic [SK_W-1:0]  ONE_C       = SK_W'(1);

  logic [SK_W-1:0] streak_q, streak_d;
  logic            safe_q, safe_d;
  logic            in_range;

  assign in_range = (meas_i >= LO_C) && (meas_i <= HI_C);

  always_comb begin
    streak_d = streak_q;
    safe_d   = safe_q;
    if (bypass_i || lost_i) begin
      streak_d = '0;
      safe_d   = 1'b0;
    end else if (meas_vld_i) begin
      if (in_range) begin
        if (streak_q != LOCK_C) begin
          streak_d = streak_q + ONE_C;
        end
        if (streak_q >= LOCK_LAST_C) begin
          safe_d = 1'b1;
        end
      end else begin
        streak_d = '0;
        safe_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
      safe_q   <= 1'b0;
    end else begin
      streak_q <= streak_d;
      safe_q   <= safe_d;
    end
  end

  assign safe_o = safe_q;
  assign upd_o  = meas_vld_i & in_range & safe_q & ~bypass_i & ~lost_i;

endmodule

// File: rtl/refmon_steer.sv
module refmon_steer #(
  parameter int NOM_CYCLES = 24000,
  parameter int GAIN       = 1,
  parameter int CNT_W      = 16,
  parameter int CW_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] meas_i,
  output logic [CW_W-1:0]  word_o
);

  localparam int GW = $clog2(GAIN + 1);
  localparam int SW = CNT_W + GW + CW_W + 2;
  localparam logic signed [SW-1:0] NOM_S  = SW'(NOM_CYCLES);
  localparam logic signed [SW-1:0] GAIN_S = SW'(GAIN);
  localparam logic signed [SW-1:0] ZERO_S = '0;
  localparam logic signed [SW-1:0] MAX_S  = SW'((2 ** CW_W) - 1);
  localparam logic [CW_W-1:0]      MID_C  = CW_W'(2 ** (CW_W - 1));

  logic [CW_W-1:0]        word_q, word_d;
  logic signed [SW-1:0]   err_s, delta_s, cand_s;

  always_comb begin
    err_s   = $signed(SW'(meas_i)) - NOM_S;
    delta_s = err_s * GAIN_S;
    cand_s  = $signed(SW'(word_q)) - delta_s;
    if (cand_s < ZERO_S) begin
      word_d = '0;
    end else if (cand_s > MAX_S) begin
      word_d = MAX_S[CW_W-1:0];
    end else begin
      word_d = cand_s[CW_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= MID_C;
    end else if (upd_i) begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/refmon_holdover.sv
module refmon_holdover #(
  parameter int NOM_CYCLES   = 24000,
  parameter int TOL_PPM      = 250,
  parameter int LOCK_PERIODS = 4,
  parameter int CW_W         = 12,
  parameter int GAIN         = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_clk_i,
  input  logic [3:0]      fsel_i,
  output logic            safe_o,
  output logic [CW_W-1:0] ctrl_word_o,
  output logic            out8k_oe_o
);

  import refmon_pkg::*;

  localparam int TOL_CYCLES = (NOM_CYCLES * TOL_PPM) / 1000000;
  localparam int CNT_W      = $clog2(2 * NOM_CYCLES + 1);

  logic             rise;
  logic [CNT_W-1:0] meas;
  logic             meas_vld;
  logic             lost;
  logic             bypass;
  logic             upd;

  assign bypass     = is_buffer_code(fsel_i);
  assign out8k_oe_o = ~bypass;

  refmon_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ref_clk_i),
    .rise_o  (rise)
  );

  refmon_period_meter #(.NOM_CYCLES(NOM_CYCLES), .CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .meas_o     (meas),
    .meas_vld_o (meas_vld),
    .lost_o     (lost)
  );

  refmon_qualifier #(
    .NOM_CYCLES   (NOM_CYCLES),
    .TOL_CYCLES   (TOL_CYCLES),
    .LOCK_PERIODS (LOCK_PERIODS),
    .CNT_W        (CNT_W)
  ) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_i     (meas),
    .meas_vld_i (meas_vld),
    .lost_i     (lost),
    .bypass_i   (bypass),
    .safe_o     (safe_o),
    .upd_o      (upd)
  );

  refmon_steer #(
    .NOM_CYCLES (NOM_CYCLES),
    .GAIN       (GAIN),
    .CNT_W      (CNT_W),
    .CW_W       (CW_W)
  ) u_steer (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (upd),
    .meas_i (meas),
    .word_o (ctrl_word_o)
  );

endmodule

// File: rtl/refmon_holdover_chk.sv
module refmon_holdover_chk #(
  parameter int NOM_CYCLES = 24000,
  parameter int TOL_CYCLES = 6,
  parameter int GAIN       = 1,
  parameter int CNT_W      = 16,
  parameter int CW_W       = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             safe_o,
  input logic [CW_W-1:0]  ctrl_word_o,
  input logic             bypass,
  input logic             meas_vld,
  input logic [CNT_W-1:0] meas,
  input logic             lost
);

  localparam int MAX_STEP = TOL_CYCLES * GAIN;
  localparam int LO = NOM_CYCLES - TOL_CYCLES;
  localparam int HI = NOM_CYCLES + TOL_CYCLES;

  assert_hold_when_unsafe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !safe_o |=> $stable(ctrl_word_o));

  assert_buffer_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !safe_o);

  assert_loss_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !safe_o);

  assert_range_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && ((int'(meas) < LO) || (int'(meas) > HI))) |=> !safe_o);

  assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word_o) |->
      (((int'(ctrl_word_o) - int'($past(ctrl_word_o))) <= MAX_STEP) &&
       ((int'($past(ctrl_word_o)) - int'(ctrl_word_o)) <= MAX_STEP)));

  assert_set_on_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(safe_o) |-> $past(meas_vld));

endmodule

bind refmon_holdover refmon_holdover_chk #(
  .NOM_CYCLES (NOM_CYCLES),
  .TOL_CYCLES (TOL_CYCLES),
  .GAIN       (GAIN),
  .CNT_W      (CNT_W),
  .CW_W       (CW_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .safe_o      (safe_o),
  .ctrl_word_o (ctrl_word_o),
  .bypass      (bypass),
  .meas_vld    (meas_vld),
  .meas        (meas),
  .lost        (lost)
);

// File: tb/refmon_holdover_bench.sv
`timescale 1ns/1ps
module refmon_holdover_bench;

  localparam int NOM  = 400;
  localparam int PPM  = 25000;
  localparam int LOCK = 3;
  localparam int CW   = 8;
  localparam int GN   = 4;
  localparam int TOL  = (NOM * PPM) / 1000000;
  localparam int TMO  = 2 * NOM;
  localparam int WMAX = (2 ** CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          ref_clk;
  logic [3:0]    fsel;
  logic          safe;
  logic [CW-1:0] word;
  logic          oe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_safe, m_streak, m_armed, m_word, since;

  refmon_holdover #(
    .NOM_CYCLES(NOM), .TOL_PPM(PPM), .LOCK_PERIODS(LOCK),
    .CW_W(CW), .GAIN(GN), .SYNC_STAGES(2)
  ) u_refmon_holdover (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .fsel_i(fsel),
    .safe_o(safe), .ctrl_word_o(word), .out8k_oe_o(oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit m_byp();
    return fsel[3:1] == 3'b111;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "safe", int'(safe), m_safe);
    chk(tag, "word", int'(word), m_word);
    chk(tag, "oe", int'(oe), m_byp() ? 0 : 1);
  endtask

  task automatic step();
    @(negedge clk);
    since++;
    if (m_armed != 0 && since > TMO) begin
      m_armed  = 0;
      m_safe   = 0;
      m_streak = 0;
    end
  endtask

  task automatic model_rise();
    if (m_armed != 0) begin
      int p = since;
      bit inr = (p >= NOM - TOL) && (p <= NOM + TOL);
      if (m_byp()) begin
        m_streak = 0; m_safe = 0;
      end else if (inr) begin
        if (m_safe != 0) begin
          m_word = m_word - (p - NOM) * GN;
          if (m_word < 0) m_word = 0;
          if (m_word > WMAX) m_word = WMAX;
        end
        if (m_streak < LOCK) m_streak++;
        if (m_streak >= LOCK) m_safe = 1;
      end else begin
        m_streak = 0; m_safe = 0;
      end
    end
    m_armed = 1;
    since = 0;
  endtask

  task automatic ref_period(input int p, input string tag);
    int h = p / 2;
    ref_clk = 1'b1;
    model_rise();
    for (int i = 0; i < h; i++) step();
    check_all(tag);
    ref_clk = 1'b0;
    for (int i = 0; i < p - h; i++) step();
  endtask

  task automatic set_fsel(input logic [3:0] v);
    fsel = v;
    if (m_byp()) begin m_safe = 0; m_streak = 0; end
    step(); step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_clk = 1'b0; fsel = 4'b0000;
    m_safe = 0; m_streak = 0; m_armed = 0; m_word = 1 << (CW - 1); since = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2, R3: first edge arms, then LOCK periods qualify
    for (int i = 0; i < 5; i++) ref_period(NOM, "R3");
    // R6: tracking in both directions
    ref_period(NOM + 5, "R6");
    ref_period(NOM - 5, "R6");
    // R6: saturation at both rails
    for (int i = 0; i < 5; i++) ref_period(NOM + TOL, "R6");
    for (int i = 0; i < 9; i++) ref_period(NOM - TOL, "R6");
    ref_period(NOM, "R6");
    // R4, R7: just outside upper bound
    ref_period(NOM + TOL + 1, "R4");
    for (int i = 0; i < 4; i++) ref_period(NOM + 2, "R7");
    // R4, R2: just outside lower bound
    ref_period(NOM - TOL - 1, "R4");
    for (int i = 0; i < 4; i++) ref_period(NOM - 3, "R2");
    // R5: gap of exactly twice nominal is measured, not lost
    ref_period(TMO, "R5");
    for (int i = 0; i < 4; i++) ref_period(NOM + 1, "R5");
    // R5, R9: one cycle longer is a loss; recovery from held word
    ref_period(TMO + 1, "R5");
    for (int i = 0; i < 5; i++) ref_period(NOM - 1, "R9");
    // R5: long silence
    for (int i = 0; i < 1200; i++) step();
    check_all("R5");
    for (int i = 0; i < 6; i++) ref_period(NOM + 3, "R9");
    // R8: buffer mode, both codes
    set_fsel(4'b1110);
    check_all("R8");
    for (int i = 0; i < 4; i++) ref_period(NOM + 4, "R8");
    set_fsel(4'b1111);
    for (int i = 0; i < 2; i++) ref_period(NOM - 4, "R8");
    set_fsel(4'b0100);
    for (int i = 0; i < 5; i++) ref_period(NOM + 2, "R8");
    // R2, R6: sweep of periods across and past the window
    for (int p = NOM - TOL - 5; p <= NOM + TOL + 5; p++) begin
      ref_period(p, "R2");
      for (int k = 0; k < LOCK + 1; k++) ref_period(NOM, "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule